// File: doc/BRIEF.md
# Scatter-Gather DMA Address Translator

This block turns the byte addresses that DMA requesters present into physical addresses. A page map is held in on-block RAM. Each map entry gives a physical page number, a valid flag and a parity bit. In the full-size configuration a 15-bit page index, taken from address bits [27:13], selects one of 32768 entries. Each entry is 24 bits wide. The 17-bit page number replaces the upper part of the address, and the low 13 bits of the page offset are kept. The result is a 30-bit physical address that covers 1 GB. The index width is the parameter `IDX_W`. It defaults to 11, which gives a 2048-entry map that elaborates cheaply, with index bits [23:13].

A configuration register holds one enable bit per requester. When a requester's bit is clear, its address is not translated: the low 30 bits pass through unchanged. Software programs and inspects the map through a plain register port.

Requests arrive on a valid/ready stream tagged with a requester ID, and results leave on a second valid/ready stream. A translation that meets a bad map entry produces no result beat. Instead it raises a one-cycle fault pulse that tells an invalid entry apart from a parity failure. Back-pressure rules are as follows:
- A held result keeps its value until it is taken.
- The request side stops accepting once both pipeline stages are occupied.
- Beats leave in the order they arrived.

Top module: `sgx_translator`

## Requirements
- R1: For an enabled requester whose entry is good, `res_addr` equals the entry's page number in bits [29:13] with request bits [12:0] in bits [12:0]. The entry layout is: valid at bit 23, parity at bit 22, bits [21:17] reserved, page number at bits [16:0].
- R2: The map index is request bits [13+IDX_W-1:13]. When translating, address bits above the index have no effect on the result.
- R3: For a requester whose enable bit is clear, `res_addr` equals request bits [29:0]. This holds whatever the indexed entry contains, and no fault is raised.
- R4: For an enabled requester whose entry has good parity but a clear valid bit, no result beat is produced. `fault_valid` pulses with `fault_parity` = 0.
- R5: Parity is odd over the page number, the valid bit and the parity bit. When this check fails, no result beat is produced and `fault_valid` pulses with `fault_parity` = 1. A parity failure takes precedence over the valid bit.
- R6: A request accepted at clock edge N yields its result beat or fault pulse after edge N+1, and not after edge N.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_addr` and `res_id` hold. `req_ready` is low only when both stages are occupied and the output is stalled. No beat is lost or reordered.
- R8: A map write stores `map_wdata` at `map_idx`. A read request puts the entry on `map_rdata`, with `map_rd_valid` high, after the next edge.
- R9: A configuration write loads the whole enable vector, where bit i enables requester i. The vector is visible on `cfg_en` after that edge and resets to all zero.
- R10: After reset, `req_ready` is 1 and `res_valid`, `fault_valid` and `map_rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Request beat accepted on this edge when valid |
| req_id | input | ID_W (3) | Requester number |
| req_addr | input | 32 | DMA byte address |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the result beat |
| res_addr | output | 30 | Physical byte address |
| res_id | output | ID_W (3) | Requester number of the result |
| fault_valid | output | 1 | One-cycle pulse: lookup hit a bad entry |
| fault_parity | output | 1 | With fault_valid: 1 parity failure, 0 invalid entry |
| map_wr_en | input | 1 | Write one map entry |
| map_rd_en | input | 1 | Read one map entry |
| map_idx | input | IDX_W (11) | Map entry number for software access |
| map_wdata | input | 24 | Entry to write |
| map_rdata | output | 24 | Entry read back |
| map_rd_valid | output | 1 | map_rdata holds a fresh read |
| cfg_wr_en | input | 1 | Load the enable vector |
| cfg_wdata | input | N_REQ (8) | New enable vector |
| cfg_en | output | N_REQ (8) | Current enable vector |

## Verification
Translation is tried with several page indices, including the highest index and the maximum page offset, so that a swapped or shifted page-number field shows up as a wrong address. A request whose address has junk above the index separates a correct index slice from one that is too wide. A disabled requester pointed at a corrupt entry tells bypass apart from a lookup that merely happens to match. Entries with a clear valid bit and with flipped parity check that the two fault kinds, and their precedence, are distinguished. A stalled consumer with three requests in flight exposes loss, duplication or reordering in the two-stage pipeline.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

  localparam int ENTRY_W   = 24;
  localparam int PPN_W     = 17;
  localparam int OFS_W     = 13;
  localparam int PA_W      = 30;
  localparam int RSVD_W    = ENTRY_W - PPN_W - 2;

  // Map entry: valid [23], parity [22], reserved [21:17], page [16:0]
  typedef struct packed {
    logic              valid;
    logic              par;
    logic [RSVD_W-1:0] rsvd;
    logic [PPN_W-1:0]  ppn;
  } sg_entry_t;

  typedef enum logic [1:0] {
    CHK_OK      = 2'd0,
    CHK_INVALID = 2'd1,
    CHK_PARITY  = 2'd2
  } chk_t;

  // Odd parity across page, valid and parity bit
  function automatic logic entry_par_ok(sg_entry_t e);
    return ^{e.ppn, e.valid, e.par};
  endfunction

  function automatic chk_t entry_check(sg_entry_t e);
    if (!entry_par_ok(e)) return CHK_PARITY;
    if (!e.valid)         return CHK_INVALID;
    return CHK_OK;
  endfunction

endpackage

// File: rtl/sgx_map_ram.sv
module sgx_map_ram
  import sgx_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               sw_rd_en,
  input  logic [IDX_W-1:0]   sw_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [ENTRY_W-1:0] sw_rd_data,
  output logic               sw_rd_valid,
  input  logic               lk_rd_en,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [ENTRY_W-1:0] lk_rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[sw_idx] <= wr_data;
  end

  // Read-before-write on both read ports
  always_ff @(posedge clk) begin
    if (sw_rd_en) sw_rd_data <= mem[sw_idx];
    if (lk_rd_en) lk_rd_data <= mem[lk_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sw_rd_valid <= 1'b0;
    else        sw_rd_valid <= sw_rd_en;
  end

  p_rd_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd_en |=> sw_rd_valid);
  p_rd_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd_valid |-> $past(sw_rd_en));

endmodule

// File: rtl/sgx_cfg_reg.sv
module sgx_cfg_reg #(
  parameter int N_REQ = 8,
  localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_REQ-1:0] wr_data,
  input  logic [ID_W-1:0]  sel_id,
  output logic [N_REQ-1:0] en_vec,
  output logic             sel_en
);

  for (genvar g = 0; g < N_REQ; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)     en_vec[g] <= 1'b0;
      else if (wr_en) en_vec[g] <= wr_data[g];
    end
  end

  always_comb begin
    sel_en = 1'b0;
    for (int i = 0; i < N_REQ; i++)
      if (sel_id == ID_W'(i)) sel_en = en_vec[i];
  end

  p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_vec == $past(wr_data));
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_vec));

endmodule

// File: rtl/sgx_lookup_pipe.sv
module sgx_lookup_pipe
  import sgx_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  output logic               accept,
  input  logic [ID_W-1:0]    req_id,
  input  logic [PA_W-1:0]    req_low,
  input  logic               req_xlat,
  input  logic [ENTRY_W-1:0] lk_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [PA_W-1:0]    res_addr,
  output logic [ID_W-1:0]    res_id,
  output logic               fault_valid,
  output logic               fault_parity
);

  logic            s1_valid;
  logic            s1_xlat;
  logic [ID_W-1:0] s1_id;
  logic [PA_W-1:0] s1_low;
  logic            out_adv;
  logic            s1_adv;
  sg_entry_t       ent;
  chk_t            chk;
  logic            bad;
  logic            unused_rsvd;

  assign out_adv   = !res_valid || res_ready;
  assign s1_adv    = s1_valid && out_adv;
  assign req_ready = !s1_valid || out_adv;
  assign accept    = req_valid && req_ready;

  assign ent         = sg_entry_t'(lk_data);
  assign chk         = entry_check(ent);
  assign bad         = s1_xlat && (chk != CHK_OK);
  assign unused_rsvd = ^ent.rsvd;

  // Stage 1: captured request; entry arrives from RAM with it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (req_ready) begin
      s1_valid <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_xlat <= req_xlat;
      s1_id   <= req_id;
      s1_low  <= req_low;
    end
  end

  // Stage 2: registered result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      fault_valid  <= 1'b0;
      fault_parity <= 1'b0;
    end else begin
      fault_valid  <= s1_adv && bad;
      fault_parity <= s1_adv && bad && (chk == CHK_PARITY);
      if (out_adv) res_valid <= s1_valid && !bad;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_adv && !bad) begin
      res_id   <= s1_id;
      res_addr <= s1_xlat ? {ent.ppn, s1_low[OFS_W-1:0]} : s1_low;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_id));
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> s1_valid && res_valid && !res_ready);
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && fault_valid && $past(res_ready)));
  p_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_parity |-> fault_valid);
  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> s1_valid);
  p_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_adv |=> res_valid || fault_valid);
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_adv && !s1_xlat |=> res_valid && !fault_valid && res_addr == $past(s1_low));

endmodule

// File: rtl/sgx_translator.sv
module sgx_translator
  import sgx_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int N_REQ = 8,
  localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int AW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ID_W-1:0]    req_id,
  input  logic [AW-1:0]      req_addr,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [PA_W-1:0]    res_addr,
  output logic [ID_W-1:0]    res_id,
  output logic               fault_valid,
  output logic               fault_parity,
  input  logic               map_wr_en,
  input  logic               map_rd_en,
  input  logic [IDX_W-1:0]   map_idx,
  input  logic [ENTRY_W-1:0] map_wdata,
  output logic [ENTRY_W-1:0] map_rdata,
  output logic               map_rd_valid,
  input  logic               cfg_wr_en,
  input  logic [N_REQ-1:0]   cfg_wdata,
  output logic [N_REQ-1:0]   cfg_en
);

  logic               accept;
  logic               sel_en;
  logic [IDX_W-1:0]   lk_idx;
  logic [ENTRY_W-1:0] lk_data;
  logic               unused_top;

  assign lk_idx     = req_addr[OFS_W +: IDX_W];
  assign unused_top = ^req_addr[AW-1:PA_W];

  sgx_cfg_reg #(.N_REQ(N_REQ)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wdata),
    .sel_id  (req_id),
    .en_vec  (cfg_en),
    .sel_en  (sel_en)
  );

  sgx_map_ram #(.IDX_W(IDX_W)) ram_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (map_wr_en),
    .sw_rd_en    (map_rd_en),
    .sw_idx      (map_idx),
    .wr_data     (map_wdata),
    .sw_rd_data  (map_rdata),
    .sw_rd_valid (map_rd_valid),
    .lk_rd_en    (accept),
    .lk_idx      (lk_idx),
    .lk_rd_data  (lk_data)
  );

  sgx_lookup_pipe #(.ID_W(ID_W)) pipe_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .accept       (accept),
    .req_id       (req_id),
    .req_low      (req_addr[PA_W-1:0]),
    .req_xlat     (sel_en),
    .lk_data      (lk_data),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_addr     (res_addr),
    .res_id       (res_id),
    .fault_valid  (fault_valid),
    .fault_parity (fault_parity)
  );

  initial begin
    assert (IDX_W >= 1 && IDX_W <= 15)
      else $error("IDX_W out of range");
  end

endmodule

// File: tb/sgx_translator_tb.sv
module sgx_translator_tb_top;

  localparam int IDX_W = 11;
  localparam int N_REQ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_id = '0;
  logic [31:0] req_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [29:0] res_addr;
  logic [2:0]  res_id;
  logic        fault_valid;
  logic        fault_parity;
  logic        map_wr_en = 1'b0;
  logic        map_rd_en = 1'b0;
  logic [IDX_W-1:0] map_idx = '0;
  logic [23:0] map_wdata = '0;
  logic [23:0] map_rdata;
  logic        map_rd_valid;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_en;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sgx_translator #(.IDX_W(IDX_W), .N_REQ(N_REQ)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_addr(req_addr),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr), .res_id(res_id),
    .fault_valid(fault_valid), .fault_parity(fault_parity),
    .map_wr_en(map_wr_en), .map_rd_en(map_rd_en), .map_idx(map_idx),
    .map_wdata(map_wdata), .map_rdata(map_rdata), .map_rd_valid(map_rd_valid),
    .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_en(cfg_en)
  );

  function automatic logic [23:0] mk_entry(logic [16:0] ppn, logic v, logic flip);
    logic p;
    p = ~(^{ppn, v}) ^ flip;
    return {v, p, 5'b0, ppn};
  endfunction

  function automatic logic [31:0] va(logic [IDX_W-1:0] idx, logic [12:0] ofs);
    return (32'(idx) << 13) | 32'(ofs);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic map_write(logic [IDX_W-1:0] idx, logic [23:0] d);
    @(negedge clk);
    map_wr_en = 1'b1; map_idx = idx; map_wdata = d;
    @(negedge clk);
    map_wr_en = 1'b0;
  endtask

  task automatic push(logic [2:0] id, logic [31:0] a);
    req_valid = 1'b1; req_id = id; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Good translation or bypass: checks latency, address and id
  task automatic expect_beat(string tag, logic [2:0] id, logic [31:0] a, logic [29:0] exp);
    @(negedge clk);
    push(id, a);
    chk({tag, " no beat before N+1 (R6)"}, 32'(res_valid), 32'd0);
    @(negedge clk);
    chk({tag, " res_valid"}, 32'(res_valid), 32'd1);
    chk({tag, " res_addr"}, 32'(res_addr), 32'(exp));
    chk({tag, " res_id"}, 32'(res_id), 32'(id));
    chk({tag, " no fault"}, 32'(fault_valid), 32'd0);
  endtask

  task automatic expect_fault(string tag, logic [2:0] id, logic [31:0] a, logic par);
    @(negedge clk);
    push(id, a);
    @(negedge clk);
    chk({tag, " fault_valid"}, 32'(fault_valid), 32'd1);
    chk({tag, " fault_parity"}, 32'(fault_parity), 32'(par));
    chk({tag, " no beat"}, 32'(res_valid), 32'd0);
    @(negedge clk);
    chk({tag, " fault is a pulse"}, 32'(fault_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R10 req_ready", 32'(req_ready), 32'd1);
    chk("R10 res_valid", 32'(res_valid), 32'd0);
    chk("R10 fault_valid", 32'(fault_valid), 32'd0);
    chk("R10 map_rd_valid", 32'(map_rd_valid), 32'd0);
    chk("R9 cfg reset", 32'(cfg_en), 32'd0);
  endtask

  task automatic t_cfg;
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wdata = 8'b0000_0101;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R9 cfg load", 32'(cfg_en), 32'h05);
  endtask

  task automatic t_map;
    map_write(11'd5,     mk_entry(17'h1ABCD, 1'b1, 1'b0));
    map_write(11'h7FF,   mk_entry(17'h00001, 1'b1, 1'b0));
    map_write(11'd3,     mk_entry(17'h15555, 1'b1, 1'b0));
    map_write(11'd9,     mk_entry(17'h0F0F0, 1'b0, 1'b0));
    map_write(11'd10,    mk_entry(17'h12345, 1'b1, 1'b1));
    map_write(11'd12,    mk_entry(17'h12345, 1'b0, 1'b1));
    @(negedge clk);
    map_rd_en = 1'b1; map_idx = 11'd5;
    @(negedge clk);
    map_rd_en = 1'b0;
    chk("R8 rd_valid", 32'(map_rd_valid), 32'd1);
    chk("R8 rdata", 32'(map_rdata), 32'(mk_entry(17'h1ABCD, 1'b1, 1'b0)));
    @(negedge clk);
    chk("R8 rd_valid drops", 32'(map_rd_valid), 32'd0);
  endtask

  task automatic t_xlat;
    expect_beat("R1 idx5", 3'd0, va(11'd5, 13'h1234), {17'h1ABCD, 13'h1234});
    expect_beat("R1 idx max", 3'd2, va(11'h7FF, 13'h1FFF), {17'h00001, 13'h1FFF});
  endtask

  task automatic t_upper;
    expect_beat("R2 upper bits ignored", 3'd0, 32'hFF00_0000 | va(11'd5, 13'h0042),
                {17'h1ABCD, 13'h0042});
  endtask

  task automatic t_bypass;
    logic [31:0] a;
    a = 32'hF000_0000 | va(11'd10, 13'h0777);
    expect_beat("R3 bypass", 3'd1, a, a[29:0]);
  endtask

  task automatic t_faults;
    expect_fault("R4 invalid entry", 3'd0, va(11'd9, 13'h0010), 1'b0);
    expect_fault("R5 parity error", 3'd2, va(11'd10, 13'h0020), 1'b1);
    expect_fault("R5 parity over invalid", 3'd0, va(11'd12, 13'h0000), 1'b1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    res_ready = 1'b0;
    push(3'd0, va(11'd3, 13'h0001));
    push(3'd2, va(11'd5, 13'h0002));
    req_valid = 1'b1; req_id = 3'd1; req_addr = 32'h0000_0ABC;
    for (int i = 0; i < 3; i++) begin
      chk("R7 req_ready low", 32'(req_ready), 32'd0);
      chk("R7 held valid", 32'(res_valid), 32'd1);
      chk("R7 held addr", 32'(res_addr), 32'({17'h15555, 13'h0001}));
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 second beat", 32'(res_addr), 32'({17'h1ABCD, 13'h0002}));
    chk("R7 second id", 32'(res_id), 32'd2);
    @(negedge clk);
    chk("R7 third beat valid", 32'(res_valid), 32'd1);
    chk("R7 third beat", 32'(res_addr), 32'h0000_0ABC);
    @(negedge clk);
    chk("R7 drained", 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cfg;
    t_map;
    t_xlat;
    t_upper;
    t_bypass;
    t_faults;
    t_backpressure;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule